// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block sits between an on-chip request/ready port and an external 16-bit asynchronous static RAM. Each host request is a single beat, either a read or a write, carrying a word address, write data and a two-bit byte mask. The controller turns the request into a timed sequence on the RAM pins. These pins are the word address, an active-low and an active-high chip select, write strobe, output enable, two active-low byte-lane enables, and a split data bus made of an output value, an output-enable and an input value. Every pin is driven from a register. All pulse widths are whole clock counts set by parameters.

A write selects the chip and enables the chosen lanes. The data bus is driven one clock before the write strobe falls. The strobe is held low for `WE_CYC` clocks and the bus stays driven for one clock after the strobe rises, so hold time at the terminating edge is more than zero. A read selects the chip with output enable low for `RD_CYC` clocks and captures the bus on the last of them. Output enable is then released and the controller waits `TURN_CYC` clocks so the RAM can release the bus before any later write drives it. A request with an all-zero mask completes without moving any strobe. When no request is in progress the chip is deselected and both lane enables are high.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no request is in progress, the outputs are: chip select low side high (`mem_ce_n`=1), high side low (`mem_ce`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_ub_n`=1, `mem_lb_n`=1, `mem_dq_oe`=0 and `req_ready`=0.
- R2: A write stores mask bit 0 into data bits 7:0 through `mem_lb_n` low, and mask bit 1 into bits 15:8 through `mem_ub_n` low. A lane whose mask bit is 0 keeps its previous contents. The word goes to the requested address.
- R3: During a write, `mem_we_n` is low for exactly `WE_CYC` consecutive clocks. While it is low, the chip is selected (`mem_ce_n`=0, `mem_ce`=1) and `mem_oe_n` is 1. During a write, `mem_oe_n` is never 0.
- R4: `mem_dq_oe` rises one clock before `mem_we_n` falls and falls one clock after `mem_we_n` rises. It is high for `WE_CYC`+2 clocks per write and is never high while `mem_oe_n` is 0.
- R5: A read holds `mem_oe_n` low with `mem_we_n` high and the chip selected for exactly `RD_CYC` clocks. The result in `rsp_rdata` holds the RAM data for lanes whose mask bit is 1 and zero for lanes whose mask bit is 0.
- R6: After a read, `mem_oe_n` is high and `mem_dq_oe` is low for `TURN_CYC` clocks before the request completes. A read never drives the data bus.
- R7: `req_ready` is high for exactly one clock per request. Counting clock edges from the edge that accepts the request to the edge after which `req_ready` is high, a write takes `WE_CYC`+3 edges and a read takes `RD_CYC`+`TURN_CYC`+1 edges. `rsp_rdata` is valid while `req_ready` is high after a read.
- R8: A request whose byte mask is 0 completes one edge after acceptance. No chip select, lane enable, strobe or bus drive changes for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_bmask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read result |
| mem_addr | output | ADDR_W | RAM word address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ub_n | output | 1 | Active-low upper lane enable |
| mem_lb_n | output | 1 | Active-low lower lane enable |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data returned by the RAM |

## Verification
The hardest case to reach is a write that follows a read at once, with a partial mask, to a word that already holds mixed data. Only this case shows together the bus turnaround, the preservation of the untouched lane and the absence of drive while output enable is low. The stimulus is a fixed-seed random mix of reads and writes with all four mask values over 64 addresses. This gives many such read-then-write pairs and overwrites. Directed sequences first build a known word, patch one lane and read each lane back alone. A bench model of the RAM answers only when selected with output enable low, and it places filler on disabled lanes so that wrong lane selection is seen.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RREL,
    ST_DONE
  } sramc_state_e;

  typedef struct packed {
    logic ce_n;
    logic ce;
    logic we_n;
    logic oe_n;
    logic ub_n;
    logic lb_n;
    logic dq_oe;
  } sramc_pins_t;

  localparam sramc_pins_t PINS_PARKED = '{ce_n: 1'b1, ce: 1'b0, we_n: 1'b1,
                                          oe_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1,
                                          dq_oe: 1'b0};

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sramc_rdcap.sv
module sramc_rdcap #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata
);
  localparam int LANE_W = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[g*LANE_W +: LANE_W] <= '0;
      end else if (capture) begin
        rdata[g*LANE_W +: LANE_W] <= lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
      end
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int WE_CYC   = 4,
  parameter int RD_CYC   = 6,
  parameter int TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_bmask,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int MAX_AB = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int MAX_C  = (MAX_AB > TURN_CYC) ? MAX_AB : TURN_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  sramc_state_e      state_q, state_d;
  sramc_pins_t       pins_q, pins_d;
  logic              accept;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              expired;
  logic              capture;
  logic              ready_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        mask_q, mask_d;

  assign accept = (state_q == ST_IDLE) && req_valid;
  assign mask_d = accept ? req_bmask : mask_q;

  // Next state and timer loading
  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_bmask == 2'b00) begin
            state_d = ST_DONE;
          end else if (req_write) begin
            state_d = ST_WSET;
          end else begin
            state_d  = ST_RACC;
            load     = 1'b1;
            load_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_WSET: begin
        state_d  = ST_WPULSE;
        load     = 1'b1;
        load_val = CNT_W'(WE_CYC - 1);
      end
      ST_WPULSE: if (expired) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_DONE;
      ST_RACC: begin
        if (expired) begin
          state_d  = ST_RREL;
          load     = 1'b1;
          load_val = CNT_W'(TURN_CYC - 1);
        end
      end
      ST_RREL:  if (expired) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Pin values wanted for the state being entered
  always_comb begin
    pins_d = PINS_PARKED;
    unique case (state_d)
      ST_WSET, ST_WPULSE, ST_WHOLD: begin
        pins_d.ce_n  = 1'b0;
        pins_d.ce    = 1'b1;
        pins_d.lb_n  = ~mask_d[0];
        pins_d.ub_n  = ~mask_d[1];
        pins_d.dq_oe = 1'b1;
        pins_d.we_n  = (state_d != ST_WPULSE);
      end
      ST_RACC: begin
        pins_d.ce_n = 1'b0;
        pins_d.ce   = 1'b1;
        pins_d.lb_n = ~mask_d[0];
        pins_d.ub_n = ~mask_d[1];
        pins_d.oe_n = 1'b0;
      end
      default: pins_d = PINS_PARKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pins_q  <= PINS_PARKED;
      ready_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_d;
      ready_q <= (state_d == ST_DONE);
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_bmask;
      end
    end
  end

  assign capture = (state_q == ST_RACC) && expired;

  sramc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sramc_rdcap #(.DATA_W(DATA_W), .LANES(2)) u_rdcap (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .lane_en (mask_q),
    .dq_in   (mem_dq_in),
    .rdata   (rsp_rdata)
  );

  assign req_ready  = ready_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_ce_n   = pins_q.ce_n;
  assign mem_ce     = pins_q.ce;
  assign mem_we_n   = pins_q.we_n;
  assign mem_oe_n   = pins_q.oe_n;
  assign mem_ub_n   = pins_q.ub_n;
  assign mem_lb_n   = pins_q.lb_n;
  assign mem_dq_oe  = pins_q.dq_oe;
endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
  parameter int WE_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic mem_ce_n,
  input logic mem_ce,
  input logic mem_we_n,
  input logic mem_oe_n,
  input logic mem_dq_oe
);
  logic [31:0] we_run;

  always_ff @(posedge clk) begin
    if (rst)            we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 1;
    else                we_run <= '0;
  end

  assert_done_parked_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_we_selected_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n));

  assert_we_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run == WE_CYC));

  assert_no_contention_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  assert_drive_before_we_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_dq_oe));

  assert_release_after_we_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe ##1 !mem_dq_oe);

  assert_read_strobes_R5: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && mem_ce));

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);
endmodule

bind sram_async_ctrl sramc_checker #(.WE_CYC(WE_CYC)) u_sramc_checker (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .mem_ce_n  (mem_ce_n),
  .mem_ce    (mem_ce),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 16;
  localparam int WE_CYC = 4;
  localparam int RD_CYC = 6;
  localparam int TURN_CYC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [1:0] req_bmask = '0;
  logic req_ready;
  logic [DATA_W-1:0] rsp_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [DATA_W-1:0] mem_dq_out;
  logic [DATA_W-1:0] mem_dq_in;

  always #5 clk = ~clk;

  sram_async_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_CYC(WE_CYC),
                    .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] dev [64];
  logic [15:0] gold [64];
  bit addr_bad = 1'b0;
  int we_lo = 0, oe_lo = 0, dq_cnt = 0, sel_cnt = 0;

  function automatic logic [ADDR_W-1:0] idx2addr(input int idx);
    logic [5:0] i6;
    i6 = idx[5:0];
    return {i6[5], 13'h1555, i6[4:0]};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] lanes(input logic [15:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  // RAM model: answers only when selected with output enable low
  always_comb begin
    logic [15:0] w;
    w = dev[{mem_addr[18], mem_addr[4:0]}];
    mem_dq_in = 16'hC3C3;
    if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_dq_in[7:0]  = w[7:0];
      if (!mem_ub_n) mem_dq_in[15:8] = w[15:8];
    end
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (!mem_we_n && !mem_ce_n && mem_ce && mem_dq_oe) begin
        if (mem_addr[17:5] != 13'h1555) addr_bad = 1'b1;
        if (!mem_lb_n) dev[{mem_addr[18], mem_addr[4:0]}][7:0]  <= mem_dq_out[7:0];
        if (!mem_ub_n) dev[{mem_addr[18], mem_addr[4:0]}][15:8] <= mem_dq_out[15:8];
      end
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
      if (mem_dq_oe) dq_cnt++;
      if (!mem_ce_n || mem_ce || !mem_ub_n || !mem_lb_n) sel_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_parked(input string req);
    chk({mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}
        == 8'b1011_1100, req,
        {24'h0, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready},
        32'hBC);
  endtask

  // One request; called and returns at a falling edge
  task automatic txn(input bit wr, input int idx, input logic [15:0] wd,
                     input logic [1:0] m);
    int n;
    int exp_n;
    logic [15:0] exp_rd;
    we_lo = 0; oe_lo = 0; dq_cnt = 0; sel_cnt = 0; addr_bad = 1'b0;
    req_valid = 1'b1; req_write = wr; req_addr = idx2addr(idx);
    req_wdata = wd; req_bmask = m;
    n = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (req_ready || n > 1000) break;
    end
    req_valid = 1'b0;
    if (m == 2'b00) begin
      exp_n = 1;
      chk(sel_cnt == 0 && we_lo == 0 && oe_lo == 0 && dq_cnt == 0, "R8 strobes",
          sel_cnt + we_lo + oe_lo + dq_cnt, 0);
      chk(n == exp_n, "R8 latency", n, exp_n);
    end else if (wr) begin
      exp_n = WE_CYC + 3;
      chk(n == exp_n, "R7 write latency", n, exp_n);
      chk(we_lo == WE_CYC, "R3 we width", we_lo, WE_CYC);
      chk(oe_lo == 0, "R3 oe during write", oe_lo, 0);
      chk(dq_cnt == WE_CYC + 2, "R4 drive window", dq_cnt, WE_CYC + 2);
      chk(!addr_bad, "R2 address", {31'h0, addr_bad}, 0);
      gold[idx] = merge(gold[idx], wd, m);
    end else begin
      exp_n = 1 + RD_CYC + TURN_CYC;
      exp_rd = lanes(gold[idx], m);
      chk(n == exp_n, "R6 R7 read latency", n, exp_n);
      chk(oe_lo == RD_CYC, "R5 oe width", oe_lo, RD_CYC);
      chk(dq_cnt == 0, "R6 no drive on read", dq_cnt, 0);
      chk(rsp_rdata == exp_rd, "R2 R5 read data", rsp_rdata, exp_rd);
    end
    @(posedge clk);
    @(negedge clk);
    chk(!req_ready, "R7 single pulse", req_ready, 0);
    chk_parked("R1 idle pins");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed_ret;
    seed_ret = $urandom(32'd20240611);
    for (int i = 0; i < 64; i++) begin
      dev[i]  = 16'h5A00 ^ 16'(i * 37);
      gold[i] = 16'h5A00 ^ 16'(i * 37);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_parked("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk_parked("R1 after reset");

    // Directed: build a word, patch one lane, read lanes alone
    txn(1'b1, 0, 16'hBEEF, 2'b11);
    txn(1'b0, 0, 16'h0000, 2'b11);
    txn(1'b1, 0, 16'h1234, 2'b01);
    txn(1'b0, 0, 16'h0000, 2'b10);
    txn(1'b0, 0, 16'h0000, 2'b01);
    txn(1'b1, 0, 16'hFFFF, 2'b00);
    txn(1'b0, 0, 16'h0000, 2'b00);
    txn(1'b0, 0, 16'h0000, 2'b11);
    txn(1'b1, 63, 16'hA55A, 2'b10);
    txn(1'b0, 63, 16'h0000, 2'b11);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      txn(1'($urandom_range(0, 1)), int'($urandom_range(0, 63)),
          16'($urandom), 2'($urandom_range(0, 3)));
    end
    for (int i = 0; i < 64; i++) txn(1'b0, i, 16'h0000, 2'b11);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule